// File: doc/BRIEF.md
# Programmable Baud-Rate Tick Generator with Status Flags

This block divides the system clock by a 16-bit constant to make the bit-rate reference for one serial channel. Software writes the constant as two bytes through a small byte-wide write port, then writes a control byte whose start bit launches the down counter. Each time the counter runs out, the block gives a one-cycle tick to the transmitter or receiver. It then reloads from whatever constant the byte registers hold at that moment, so a new constant applies from the next period. A constant of zero halts the counter.

Every expiry is also recorded in a status flag. By default it lands in a baud-pending flag. When both the baud interrupt enable and the external/status interrupt enable inputs are high, the expiry is routed into the external-pending flag and the baud-pending flag is cleared. A clear input wipes both flags.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor is the value {byte at address 0, byte at address 1}: address 0 holds the high byte and address 1 the low byte. A running generator ticks once every divisor clock cycles.
- R2: A divisor of zero stops the generator. A start issued while the divisor is zero produces no tick. A reload that finds the divisor at zero halts the counter, and no further ticks follow.
- R3: A write to address 2 with bit 0 set starts or restarts the counter from the current divisor. The first tick appears exactly divisor cycles after the write edge. A write to address 2 with bit 0 clear stops the counter.
- R4: When an expiry occurs and the two enables are not both high, baud_pend is set and ext_pend is left unchanged.
- R5: When an expiry occurs with baud_irq_en and ext_irq_en both high, ext_pend is set and baud_pend is cleared.
- R6: Both pending flags hold their value in every cycle that has neither an expiry nor a clear.
- R7: On expiry the counter reloads from the divisor registers as they stand at that moment. A divisor written mid-period first affects the following period. Between reloads the count falls by one per cycle.
- R8: clr_pend clears both flags in one cycle. If an expiry falls in the same cycle, the flag that the expiry sets ends up set.
- R9: tick is high for exactly one cycle per expiry.
- R10: After reset the counter is stopped, tick is low and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W (2) | Write address: 0 divisor high, 1 divisor low, 2 control |
| wr_data | input | BYTE_W (8) | Write data byte |
| baud_irq_en | input | 1 | Baud interrupt enable |
| ext_irq_en | input | 1 | External/status interrupt enable |
| clr_pend | input | 1 | Clear both pending flags |
| tick | output | 1 | One-cycle pulse at each expiry |
| baud_pend | output | 1 | Baud expiry pending flag |
| ext_pend | output | 1 | External/status pending flag |

## Verification
A counter expiry and a pending-flag clear can land on the same clock edge. The bench sets up this collision by waiting for one tick and then counting divisor minus one cycles. It then raises clr_pend for a single cycle, so the clear edge is the next expiry edge. It runs the collision once with the enables routing the expiry to baud_pend and once with them routing it to ext_pend. The pass condition is that the flag the expiry targets reads set while the other flag reads clear.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Control byte bit that starts (1) or stops (0) the generator
    localparam int CTRL_RUN_BIT = 0;

    typedef struct packed {
        logic baud_pend;
        logic ext_pend;
    } flag_state_t;

endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    parameter int ADDR_W = 2,
    localparam int DIV_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  divisor,
    output logic              load,
    output logic              halt
);
    import baud_pkg::*;

    localparam int CTRL_ADDR = NBYTES;

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] div;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic ctrl_hit;

    always_comb begin
        st_d = st_q;
        // byte b (0 = least significant) sits at address NBYTES-1-b
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_en && wr_addr == ADDR_W'(NBYTES - 1 - b)) begin
                st_d.div[b] = wr_data;
            end
        end
        ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
        load     = ctrl_hit && wr_data[CTRL_RUN_BIT];
        halt     = ctrl_hit && !wr_data[CTRL_RUN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign divisor = st_q.div;

endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             load,
    input  logic             halt,
    output logic             expire,
    output logic             tick
);
    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic div_zero;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        div_zero  = (divisor == '0);
        expire    = 1'b0;
        if (halt) begin
            st_d.run = 1'b0;
        end else if (load) begin
            st_d.run = !div_zero;
            st_d.cnt = divisor;
        end else if (st_q.run && st_q.cnt == DIV_W'(1)) begin
            expire    = 1'b1;
            st_d.tick = 1'b1;
            st_d.cnt  = divisor;
            st_d.run  = !div_zero;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    // R2
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt != '0));

    // R2
    zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && divisor == '0) |=> !st_q.run);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt > DIV_W'(1) && !load && !halt)
        |=> (st_q.cnt == $past(st_q.cnt) - DIV_W'(1)));

endmodule

// File: rtl/baud_flags.sv
module baud_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic baud_irq_en,
    input  logic ext_irq_en,
    input  logic clr_pend,
    output logic baud_pend,
    output logic ext_pend
);
    import baud_pkg::*;

    flag_state_t st_d, st_q;
    logic route_ext;

    always_comb begin
        st_d      = st_q;
        route_ext = baud_irq_en && ext_irq_en;
        if (clr_pend) begin
            st_d.baud_pend = 1'b0;
            st_d.ext_pend  = 1'b0;
        end
        if (expire) begin
            if (route_ext) begin
                st_d.ext_pend  = 1'b1;
                st_d.baud_pend = 1'b0;
            end else begin
                st_d.baud_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_pend = st_q.baud_pend;
    assign ext_pend  = st_q.ext_pend;

    // R4
    baud_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(baud_irq_en && ext_irq_en)) |=> baud_pend);

    // R5
    ext_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && baud_irq_en && ext_irq_en) |=> (ext_pend && !baud_pend));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !expire) |=> (!baud_pend && !ext_pend));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_pend && !expire) |=> $stable({baud_pend, ext_pend}));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int ADDR_W = $clog2(NBYTES + 1),
    localparam int DIV_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              baud_irq_en,
    input  logic              ext_irq_en,
    input  logic              clr_pend,
    output logic              tick,
    output logic              baud_pend,
    output logic              ext_pend
);
    logic [DIV_W-1:0] divisor;
    logic             load;
    logic             halt;
    logic             expire;

    baud_regs #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .divisor (divisor),
        .load    (load),
        .halt    (halt)
    );

    baud_counter #(
        .DIV_W (DIV_W)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .load    (load),
        .halt    (halt),
        .expire  (expire),
        .tick    (tick)
    );

    baud_flags i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .baud_irq_en (baud_irq_en),
        .ext_irq_en  (ext_irq_en),
        .clr_pend    (clr_pend),
        .baud_pend   (baud_pend),
        .ext_pend    (ext_pend)
    );

    // R9
    tick_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tick);

endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       baud_irq_en = 1'b0;
    logic       ext_irq_en = 1'b0;
    logic       clr_pend = 1'b0;
    logic       tick, baud_pend, ext_pend;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    baud_tick_gen i_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .baud_irq_en(baud_irq_en), .ext_irq_en(ext_irq_en),
        .clr_pend(clr_pend), .tick(tick), .baud_pend(baud_pend), .ext_pend(ext_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic clear_pulse();
        clr_pend = 1'b1;
        step();
        clr_pend = 1'b0;
    endtask

    task automatic wait_tick(input int limit, output int n);
        n = -1;
        for (int k = 1; k <= limit; k++) begin
            step();
            if (tick) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic expect_quiet(input int len, input string tag);
        int seen = 0;
        for (int k = 0; k < len; k++) begin
            step();
            if (tick) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset();
        check(tick == 1'b0, "R10 tick", tick, 0);
        check(baud_pend == 1'b0, "R10 baud_pend", baud_pend, 0);
        check(ext_pend == 1'b0, "R10 ext_pend", ext_pend, 0);
        expect_quiet(10, "R10 no tick after reset");
    endtask

    task automatic t_basic();
        int n;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h01);
        wait_tick(50, n);
        check(n == 5, "R3 first tick delay", n, 5);
        check(baud_pend == 1'b1, "R4 baud_pend set", baud_pend, 1);
        check(ext_pend == 1'b0, "R4 ext_pend untouched", ext_pend, 0);
        step();
        check(tick == 1'b0, "R9 single cycle tick", tick, 0);
        wait_tick(50, n);
        check(n == 4, "R1 period five", n + 1, 5);
    endtask

    task automatic t_big();
        int n;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h01);
        wait_tick(600, n);
        check(n == 259, "R1 high byte weight", n, 259);
        wait_tick(600, n);
        check(n == 259, "R1 period 259", n, 259);
    endtask

    task automatic t_restart_change();
        int n;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h06);
        wr(2'd2, 8'h01);
        wait_tick(50, n);
        check(n == 6, "R3 restart delay", n, 6);
        wr(2'd1, 8'h03);
        wait_tick(50, n);
        check(n == 5, "R7 old period finishes", n + 1, 6);
        wait_tick(50, n);
        check(n == 3, "R7 new period", n, 3);
    endtask

    task automatic t_stop_zero();
        int n;
        wr(2'd2, 8'h00);
        expect_quiet(20, "R3 stop");
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        expect_quiet(30, "R2 start with zero");
        wr(2'd1, 8'h04);
        wr(2'd2, 8'h01);
        wait_tick(50, n);
        check(n == 4, "R3 start after zero", n, 4);
        wr(2'd1, 8'h00);
        wait_tick(50, n);
        check(n == 3, "R2 last tick before halt", n + 1, 4);
        expect_quiet(20, "R2 reload zero halts");
    endtask

    task automatic t_flags();
        int n;
        clear_pulse();
        check(baud_pend == 1'b0 && ext_pend == 1'b0, "R8 clear both",
              {baud_pend, ext_pend}, 0);
        baud_irq_en = 1'b1; ext_irq_en = 1'b1;
        wr(2'd1, 8'h04);
        wr(2'd2, 8'h01);
        wait_tick(50, n);
        check(ext_pend == 1'b1 && baud_pend == 1'b0, "R5 routed to ext",
              {baud_pend, ext_pend}, 1);
        baud_irq_en = 1'b0;
        wait_tick(50, n);
        check(ext_pend == 1'b1 && baud_pend == 1'b1, "R6 ext held R4 baud set",
              {baud_pend, ext_pend}, 3);
        step();
        step();
        check(ext_pend == 1'b1 && baud_pend == 1'b1, "R6 hold between expiries",
              {baud_pend, ext_pend}, 3);
        clear_pulse();
        check(baud_pend == 1'b0 && ext_pend == 1'b0, "R8 clear both again",
              {baud_pend, ext_pend}, 0);
    endtask

    task automatic t_collide();
        int n;
        // divisor is 4 and running; first set ext_pend
        baud_irq_en = 1'b1; ext_irq_en = 1'b1;
        wait_tick(50, n);
        check(ext_pend == 1'b1, "R5 ext before collision", ext_pend, 1);
        baud_irq_en = 1'b0;
        for (int k = 0; k < 3; k++) step();
        clear_pulse();
        check(tick == 1'b1, "R8 collision edge aligned", tick, 1);
        check(baud_pend == 1'b1 && ext_pend == 1'b0, "R8 expiry beats clear (baud)",
              {baud_pend, ext_pend}, 2);
        baud_irq_en = 1'b1;
        for (int k = 0; k < 3; k++) step();
        clear_pulse();
        check(tick == 1'b1, "R8 collision edge aligned 2", tick, 1);
        check(baud_pend == 1'b0 && ext_pend == 1'b1, "R8 expiry beats clear (ext)",
              {baud_pend, ext_pend}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_big();
        t_restart_change();
        t_stop_zero();
        t_flags();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule